// File: doc/BRIEF.md
# Serial Peripheral Slave with Command Decode, Status Word and Bit Buffer

This block is the target end of a four-wire serial link. While chip select is low, it shifts in an 8-bit command from the controller, most significant bit first. The command selects one of four operations: store a status word, return the status word, store data into a 512-bit buffer, or return data from that buffer. Status operations move a status word whose length is programmable. Buffer operations first take an address of programmable length, which gives the starting bit position in the buffer. An optional dummy phase can follow, and then the data bits move. Each bit goes to or comes from the next buffer position, and the position wraps at the buffer end.

Clock, data and select arrive already synchronised to the system clock. Select is a level. The serial clock arrives as two one-cycle strobes, one for its rising edge and one for its falling edge. A select input chooses which strobe samples data. The block drives its data output combinationally from its registered phase and position, so each bit is valid a full half-period before the controller samples it. Every completed operation raises a sticky flag of its own and a common completion flag. A mask reduces the five flags to a single interrupt line.

Top module: `spi_slv_cmd_dec`

## Requirements
- R1: After reset, miso_o is 0, irq_o is 0, raw_o is 0 and sts_o is 0.
- R2: With cmd_def_i = 0 the command codes are fixed: 1 stores status, 4 returns status, 2 stores buffer data and 3 returns buffer data.
- R3: With cmd_def_i = 1 the codes come from cmd_code_i, indexed by operation: 0 returns buffer data, 1 stores buffer data, 2 returns status, 3 stores status. The lowest index wins when two codes are equal.
- R4: Status operations move sts_len_i+1 bits, most significant first. The first bit maps to status bit sts_len_i and the last to bit 0. Status bits above sts_len_i are left unchanged.
- R5: Buffer-store takes wr_alen_i+1 address bits and buffer-return takes rd_alen_i+1 address bits, most significant first. The low 9 received bits give the start position, and the position increments by one per data bit, wrapping from 511 to 0.
- R6: Both buffer operations move buf_len_i+1 data bits. Each bit maps to the buffer position described in R5.
- R7: When dum_en_i[op] is 1, dum_len_i[op]+1 ignored clock cycles follow the address (buffer operations) or the command (status operations), using the operation index of R3. miso_o stays 0 during them.
- R8: When an operation completes its full length, raw_o sets bit op (index as in R3) and bit 4. Bits stay set until written 1 in irq_clr_i. irq_o is 1 exactly when raw_o & int_en_i is nonzero.
- R9: edge_sel_i = 1 samples mosi_i on sck_rise_i; edge_sel_i = 0 samples it on sck_fall_i. The other strobe has no effect.
- R10: An unrecognised command keeps miso_o at 0 and ignores all further bits until cs_n_i rises: no status or buffer change and no flag.
- R11: cs_n_i rising aborts the operation and no flag is raised. Bits already stored remain, and the next frame starts again with a command.
- R12: miso_o is 0 whenever cs_n_i is high, and outside the data phase of a returning operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cs_n_i | input | 1 | Synchronised chip select, active low |
| sck_rise_i | input | 1 | One-cycle strobe on serial clock rising edge |
| sck_fall_i | input | 1 | One-cycle strobe on serial clock falling edge |
| mosi_i | input | 1 | Serial data from the controller |
| miso_o | output | 1 | Serial data to the controller |
| edge_sel_i | input | 1 | 1: sample on rising strobe, 0: on falling strobe |
| cmd_def_i | input | 1 | 1: programmed command codes, 0: fixed codes |
| cmd_code_i | input | 4 x 8 | Programmed command code per operation |
| wr_alen_i | input | 6 | Buffer-store address length minus one |
| rd_alen_i | input | 6 | Buffer-return address length minus one |
| buf_len_i | input | 9 | Buffer data length minus one |
| sts_len_i | input | 5 | Status length minus one |
| dum_en_i | input | 4 | Dummy phase enable per operation |
| dum_len_i | input | 4 x 8 | Dummy cycles minus one per operation |
| int_en_i | input | 5 | Interrupt mask over raw_o |
| irq_clr_i | input | 5 | Write-one clear of raw_o bits |
| raw_o | output | 5 | Sticky completion flags |
| irq_o | output | 1 | Masked interrupt |
| sts_o | output | 32 | Current status word |

## Verification
The properties assume that the strobes are single-cycle pulses that never coincide and that each is separated by idle cycles. They also assume that cs_n_i changes only while no strobe is active and that configuration inputs hold steady during a frame. The stimulus keeps to these assumptions: it drives every input on the falling system clock edge and issues each strobe for exactly one cycle with gaps around it. Between the sampling strobe and the opposite strobe it inverts mosi_i, so a design listening on the wrong edge would capture the complement of the intended data. Configuration changes only while select is high.

// File: rtl/spi_slv_pkg.sv
package spi_slv_pkg;
  localparam int NUM_OPS = 4;
  localparam int NUM_IRQ = NUM_OPS + 1;
  localparam int CMD_W   = 8;

  typedef enum logic [1:0] {
    OP_RDB = 2'd0,
    OP_WRB = 2'd1,
    OP_RDS = 2'd2,
    OP_WRS = 2'd3
  } op_e;

  typedef enum logic [2:0] {
    PH_CMD, PH_ADDR, PH_DUMMY, PH_DATA, PH_HALT
  } phase_e;

  function automatic logic is_buf(op_e op);
    return (op == OP_RDB) || (op == OP_WRB);
  endfunction

  function automatic logic [CMD_W-1:0] fixed_code(op_e op);
    case (op)
      OP_RDB:  return 8'd3;
      OP_WRB:  return 8'd2;
      OP_RDS:  return 8'd4;
      default: return 8'd1;
    endcase
  endfunction
endpackage

// File: rtl/spi_slv_cmd_match.sv
module spi_slv_cmd_match
  import spi_slv_pkg::*;
(
  input  logic                          cmd_def_i,
  input  logic [NUM_OPS-1:0][CMD_W-1:0] cmd_code_i,
  input  logic [CMD_W-1:0]              word_i,
  output logic                          hit_o,
  output op_e                           op_o
);
  logic [NUM_OPS-1:0] hit_vec;

  for (genvar k = 0; k < NUM_OPS; k++) begin : g_code
    logic [CMD_W-1:0] code;
    assign code       = cmd_def_i ? cmd_code_i[k] : fixed_code(op_e'(2'(k)));
    assign hit_vec[k] = (word_i == code);
  end

  assign hit_o = |hit_vec;

  // lowest operation index wins on duplicate codes
  always_comb begin
    op_o = OP_RDB;
    for (int k = NUM_OPS - 1; k >= 0; k--)
      if (hit_vec[k]) op_o = op_e'(2'(k));
  end
endmodule

// File: rtl/spi_slv_seq.sv
module spi_slv_seq
  import spi_slv_pkg::*;
#(
  parameter int BUF_BITS = 512,
  parameter int ALEN_W   = 6,
  parameter int DLEN_W   = 8,
  parameter int BLEN_W   = 9,
  parameter int SLEN_W   = 5,
  localparam int PTR_W   = $clog2(BUF_BITS),
  localparam int CNT_W   = (BLEN_W > DLEN_W) ? BLEN_W : DLEN_W
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic                           cs_n_i,
  input  logic                           smp_i,
  input  logic                           mosi_i,
  input  logic [ALEN_W-1:0]              wr_alen_i,
  input  logic [ALEN_W-1:0]              rd_alen_i,
  input  logic [BLEN_W-1:0]              buf_len_i,
  input  logic [SLEN_W-1:0]              sts_len_i,
  input  logic [NUM_OPS-1:0]             dum_en_i,
  input  logic [NUM_OPS-1:0][DLEN_W-1:0] dum_len_i,
  input  logic                           hit_i,
  input  op_e                            hit_op_i,
  output logic [CMD_W-1:0]               word_o,
  output phase_e                         phase_o,
  output op_e                            op_o,
  output logic [CNT_W-1:0]               cnt_o,
  output logic [PTR_W-1:0]               ptr_o,
  output logic                           done_o
);
  phase_e           phase_q;
  op_e              op_q;
  logic [CNT_W-1:0] cnt_q, alen, dlen;
  logic [CMD_W-2:0] cmd_sr_q;
  logic [PTR_W-2:0] addr_q;
  logic [PTR_W-1:0] ptr_q;
  logic             done_q;

  assign word_o = {cmd_sr_q, mosi_i};
  assign alen   = (op_q == OP_WRB) ? CNT_W'(wr_alen_i) : CNT_W'(rd_alen_i);
  assign dlen   = is_buf(op_q) ? CNT_W'(buf_len_i) : CNT_W'(sts_len_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q  <= PH_CMD;
      op_q     <= OP_RDB;
      cnt_q    <= '0;
      cmd_sr_q <= '0;
      addr_q   <= '0;
      ptr_q    <= '0;
      done_q   <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (cs_n_i) begin
        phase_q  <= PH_CMD;
        cnt_q    <= '0;
        cmd_sr_q <= '0;
        addr_q   <= '0;
        ptr_q    <= '0;
      end else if (smp_i) begin
        case (phase_q)
          PH_CMD: begin
            cmd_sr_q <= word_o[CMD_W-2:0];
            if (cnt_q == CNT_W'(CMD_W - 1)) begin
              cnt_q <= '0;
              op_q  <= hit_op_i;
              if (!hit_i)                phase_q <= PH_HALT;
              else if (is_buf(hit_op_i)) phase_q <= PH_ADDR;
              else if (dum_en_i[hit_op_i]) phase_q <= PH_DUMMY;
              else                       phase_q <= PH_DATA;
            end else cnt_q <= cnt_q + 1'b1;
          end
          PH_ADDR: begin
            addr_q <= {addr_q[PTR_W-3:0], mosi_i};
            if (cnt_q == alen) begin
              cnt_q   <= '0;
              ptr_q   <= {addr_q, mosi_i};
              phase_q <= dum_en_i[op_q] ? PH_DUMMY : PH_DATA;
            end else cnt_q <= cnt_q + 1'b1;
          end
          PH_DUMMY: begin
            if (cnt_q == CNT_W'(dum_len_i[op_q])) begin
              cnt_q   <= '0;
              phase_q <= PH_DATA;
            end else cnt_q <= cnt_q + 1'b1;
          end
          PH_DATA: begin
            ptr_q <= ptr_q + 1'b1;
            if (cnt_q == dlen) begin
              cnt_q   <= '0;
              phase_q <= PH_HALT;
              done_q  <= 1'b1;
            end else cnt_q <= cnt_q + 1'b1;
          end
          default: ;
        endcase
      end
    end
  end

  assign phase_o = phase_q;
  assign op_o    = op_q;
  assign cnt_o   = cnt_q;
  assign ptr_o   = ptr_q;
  assign done_o  = done_q;
endmodule

// File: rtl/spi_slv_store.sv
module spi_slv_store
  import spi_slv_pkg::*;
#(
  parameter int BUF_BITS = 512,
  parameter int SLEN_W   = 5,
  localparam int PTR_W   = $clog2(BUF_BITS),
  localparam int STS_W   = 1 << SLEN_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cs_n_i,
  input  logic              smp_i,
  input  logic              mosi_i,
  input  phase_e            phase_i,
  input  op_e               op_i,
  input  logic [SLEN_W-1:0] cnt_i,
  input  logic [PTR_W-1:0]  ptr_i,
  input  logic [SLEN_W-1:0] sts_len_i,
  output logic              miso_o,
  output logic [STS_W-1:0]  sts_o
);
  logic [BUF_BITS-1:0] buf_q;
  logic [STS_W-1:0]    sts_q;
  logic [SLEN_W-1:0]   sidx;
  logic                act;

  assign sidx = sts_len_i - cnt_i;
  assign act  = !cs_n_i && (phase_i == PH_DATA);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      buf_q <= '0;
      sts_q <= '0;
    end else if (act && smp_i) begin
      if (op_i == OP_WRB) buf_q[ptr_i] <= mosi_i;
      if (op_i == OP_WRS) sts_q[sidx]  <= mosi_i;
    end
  end

  always_comb begin
    miso_o = 1'b0;
    if (act && op_i == OP_RDB) miso_o = buf_q[ptr_i];
    if (act && op_i == OP_RDS) miso_o = sts_q[sidx];
  end

  assign sts_o = sts_q;
endmodule

// File: rtl/spi_slv_irq.sv
module spi_slv_irq
  import spi_slv_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               done_i,
  input  op_e                op_i,
  input  logic [NUM_IRQ-1:0] clr_i,
  input  logic [NUM_IRQ-1:0] en_i,
  output logic [NUM_IRQ-1:0] raw_o,
  output logic               irq_o
);
  logic [NUM_IRQ-1:0] raw_q, set_v;

  always_comb begin
    set_v = '0;
    if (done_i) begin
      set_v[op_i]    = 1'b1;
      set_v[NUM_OPS] = 1'b1;
    end
  end

  // a new completion wins over a clear in the same cycle
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) raw_q <= '0;
    else         raw_q <= (raw_q & ~clr_i) | set_v;
  end

  assign raw_o = raw_q;
  assign irq_o = |(raw_q & en_i);
endmodule

// File: rtl/spi_slv_cmd_dec.sv
module spi_slv_cmd_dec
  import spi_slv_pkg::*;
#(
  parameter int BUF_BITS = 512,
  parameter int ALEN_W   = 6,
  parameter int DLEN_W   = 8,
  parameter int BLEN_W   = 9,
  parameter int SLEN_W   = 5,
  localparam int STS_W   = 1 << SLEN_W
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic                           cs_n_i,
  input  logic                           sck_rise_i,
  input  logic                           sck_fall_i,
  input  logic                           mosi_i,
  output logic                           miso_o,
  input  logic                           edge_sel_i,
  input  logic                           cmd_def_i,
  input  logic [NUM_OPS-1:0][CMD_W-1:0]  cmd_code_i,
  input  logic [ALEN_W-1:0]              wr_alen_i,
  input  logic [ALEN_W-1:0]              rd_alen_i,
  input  logic [BLEN_W-1:0]              buf_len_i,
  input  logic [SLEN_W-1:0]              sts_len_i,
  input  logic [NUM_OPS-1:0]             dum_en_i,
  input  logic [NUM_OPS-1:0][DLEN_W-1:0] dum_len_i,
  input  logic [NUM_IRQ-1:0]             int_en_i,
  input  logic [NUM_IRQ-1:0]             irq_clr_i,
  output logic [NUM_IRQ-1:0]             raw_o,
  output logic                           irq_o,
  output logic [STS_W-1:0]               sts_o
);
  localparam int PTR_W = $clog2(BUF_BITS);
  localparam int CNT_W = (BLEN_W > DLEN_W) ? BLEN_W : DLEN_W;

  logic             smp, hit, done;
  logic [CMD_W-1:0] word;
  op_e              hit_op, op;
  phase_e           phase;
  logic [CNT_W-1:0] cnt;
  logic [PTR_W-1:0] ptr;

  assign smp = edge_sel_i ? sck_rise_i : sck_fall_i;

  spi_slv_cmd_match u_match (
    .cmd_def_i (cmd_def_i),
    .cmd_code_i(cmd_code_i),
    .word_i    (word),
    .hit_o     (hit),
    .op_o      (hit_op)
  );

  spi_slv_seq #(
    .BUF_BITS(BUF_BITS), .ALEN_W(ALEN_W), .DLEN_W(DLEN_W),
    .BLEN_W(BLEN_W), .SLEN_W(SLEN_W)
  ) u_seq (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .cs_n_i   (cs_n_i),
    .smp_i    (smp),
    .mosi_i   (mosi_i),
    .wr_alen_i(wr_alen_i),
    .rd_alen_i(rd_alen_i),
    .buf_len_i(buf_len_i),
    .sts_len_i(sts_len_i),
    .dum_en_i (dum_en_i),
    .dum_len_i(dum_len_i),
    .hit_i    (hit),
    .hit_op_i (hit_op),
    .word_o   (word),
    .phase_o  (phase),
    .op_o     (op),
    .cnt_o    (cnt),
    .ptr_o    (ptr),
    .done_o   (done)
  );

  spi_slv_store #(.BUF_BITS(BUF_BITS), .SLEN_W(SLEN_W)) u_store (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .cs_n_i   (cs_n_i),
    .smp_i    (smp),
    .mosi_i   (mosi_i),
    .phase_i  (phase),
    .op_i     (op),
    .cnt_i    (cnt[SLEN_W-1:0]),
    .ptr_i    (ptr),
    .sts_len_i(sts_len_i),
    .miso_o   (miso_o),
    .sts_o    (sts_o)
  );

  spi_slv_irq u_irq (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .done_i(done),
    .op_i  (op),
    .clr_i (irq_clr_i),
    .en_i  (int_en_i),
    .raw_o (raw_o),
    .irq_o (irq_o)
  );
endmodule

// File: rtl/spi_slv_cmd_dec_chk.sv
module spi_slv_cmd_dec_chk
  import spi_slv_pkg::*;
#(
  parameter int SLEN_W = 5,
  localparam int STS_W = 1 << SLEN_W
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               cs_n_i,
  input logic               sck_rise_i,
  input logic               sck_fall_i,
  input logic               edge_sel_i,
  input logic               miso_o,
  input logic [NUM_IRQ-1:0] irq_clr_i,
  input logic [NUM_IRQ-1:0] raw_o,
  input logic [STS_W-1:0]   sts_o
);
  // R12: no drive while deselected
  p_miso_idle_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_n_i && $past(cs_n_i) |-> !miso_o);

  // R8: every per-operation flag comes with the common completion flag
  p_flag_common_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    |(raw_o[NUM_OPS-1:0] & ~$past(raw_o[NUM_OPS-1:0])) |-> raw_o[NUM_OPS]);

  // R8: a full clear while deselected empties the flags
  p_flag_clear_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (&irq_clr_i) && cs_n_i && $past(cs_n_i) |=> raw_o == '0);

  // R11: completion only ever follows a selected cycle
  p_flag_selected_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    |(raw_o & ~$past(raw_o)) |-> !$past(cs_n_i));

  // R9: status only moves after the chosen strobe while selected
  p_sts_edge_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sts_o != $past(sts_o) |->
      !$past(cs_n_i) && $past(edge_sel_i ? sck_rise_i : sck_fall_i));
endmodule

bind spi_slv_cmd_dec spi_slv_cmd_dec_chk #(.SLEN_W(SLEN_W)) u_chk (.*);

// File: tb/spi_slv_cmd_dec_tb.sv
module spi_slv_cmd_dec_tb_top;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cs_n = 1'b1, sck_rise = 1'b0, sck_fall = 1'b0, mosi = 1'b0, miso;
  logic edge_sel = 1'b1, cmd_def = 1'b0;
  logic [3:0][7:0] cmd_code = '0, dum_len = '0;
  logic [5:0] wr_alen = 6'd7, rd_alen = 6'd7;
  logic [8:0] buf_len = 9'd15;
  logic [4:0] sts_len = 5'd7;
  logic [3:0] dum_en = '0;
  logic [4:0] int_en = 5'h1F, irq_clr = '0, raw;
  logic irq;
  logic [31:0] sts;

  always #(CLK_PERIOD/2) clk = ~clk;

  spi_slv_cmd_dec dut_i (
    .clk_i(clk), .rst_ni(rst_n), .cs_n_i(cs_n), .sck_rise_i(sck_rise),
    .sck_fall_i(sck_fall), .mosi_i(mosi), .miso_o(miso), .edge_sel_i(edge_sel),
    .cmd_def_i(cmd_def), .cmd_code_i(cmd_code), .wr_alen_i(wr_alen),
    .rd_alen_i(rd_alen), .buf_len_i(buf_len), .sts_len_i(sts_len),
    .dum_en_i(dum_en), .dum_len_i(dum_len), .int_en_i(int_en),
    .irq_clr_i(irq_clr), .raw_o(raw), .irq_o(irq), .sts_o(sts)
  );

  typedef struct { logic b; string tag; } exp_t;
  exp_t exp_q[$];
  event mon_ev;
  int n_chk = 0, n_err = 0;
  logic mbuf [512];

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  // monitor: compare miso with the queued expectation
  initial forever begin
    exp_t it;
    @(mon_ev);
    it = exp_q.pop_front();
    check(it.tag, {31'd0, miso}, {31'd0, it.b});
  end

  task automatic xbit(logic b, logic chk, logic exp, string tag);
    @(negedge clk) mosi = b;
    @(negedge clk);
    if (chk) begin exp_q.push_back('{exp, tag}); ->mon_ev; end
    if (edge_sel) sck_rise = 1'b1; else sck_fall = 1'b1;
    @(negedge clk) begin sck_rise = 1'b0; sck_fall = 1'b0; mosi = ~b; end
    if (edge_sel) sck_fall = 1'b1; else sck_rise = 1'b1;
    @(negedge clk) begin sck_rise = 1'b0; sck_fall = 1'b0; end
  endtask

  // send bits msb first, checking that miso stays idle
  task automatic send(logic [31:0] v, int n, string tag);
    for (int i = n - 1; i >= 0; i--) xbit(v[i], 1'b1, 1'b0, tag);
  endtask

  task automatic recv(logic [31:0] v, int n, string tag);
    for (int i = n - 1; i >= 0; i--) xbit(1'b0, 1'b1, v[i], tag);
  endtask

  task automatic cs_lo(); @(negedge clk) cs_n = 1'b0; @(negedge clk); endtask
  task automatic cs_hi(); @(negedge clk) cs_n = 1'b1; repeat (3) @(negedge clk); endtask
  task automatic clr_all();
    @(negedge clk) irq_clr = 5'h1F; @(negedge clk) irq_clr = '0;
  endtask

  task automatic model_wr(int off, logic [31:0] v, int n);
    for (int k = 0; k < n; k++) mbuf[(off + k) % 512] = v[n-1-k];
  endtask

  function automatic logic [31:0] model_rd(int off, int n);
    logic [31:0] r = '0;
    for (int k = 0; k < n; k++) r[n-1-k] = mbuf[(off + k) % 512];
    return r;
  endfunction

  initial begin
    #(CLK_PERIOD * 200000);
    n_err++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_err);
    $finish;
  end

  initial begin
    for (int i = 0; i < 512; i++) mbuf[i] = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 miso", {31'd0, miso}, 0);
    check("R1 irq", {31'd0, irq}, 0);
    check("R1 raw", {27'd0, raw}, 0);
    check("R1 sts", sts, 0);

    // R2 fixed store-status then return-status
    cs_lo(); send(1, 8, "R2 cmd idle"); send(32'hA5, 8, "R2"); cs_hi();
    check("R2 sts", sts, 32'hA5);
    check("R8 raw wrs", {27'd0, raw}, 5'b11000);
    check("R8 irq", {31'd0, irq}, 1);
    clr_all();
    check("R8 clear", {27'd0, raw}, 0);
    cs_lo(); send(4, 8, "R12 cmd idle"); recv(32'hA5, 8, "R2 rds"); cs_hi();
    check("R8 raw rds", {27'd0, raw}, 5'b10100);
    clr_all();

    // R4 short status
    sts_len = 5'd3;
    cs_lo(); send(1, 8, "R4 cmd"); send(4'hF, 4, "R4"); cs_hi();
    check("R4 sts partial", sts, 32'hAF);
    cs_lo(); send(4, 8, "R4 cmd"); recv(4'hF, 4, "R4 rds"); cs_hi();
    sts_len = 5'd7;
    clr_all();

    // R5 R6 buffer store / return at offset 252
    cs_lo(); send(2, 8, "R5 cmd"); send(8'hFC, 8, "R5 addr"); send(16'hC3A5, 16, "R6");
    cs_hi(); model_wr(252, 16'hC3A5, 16);
    cs_lo(); send(3, 8, "R5 cmd"); send(8'hFC, 8, "R5 addr");
    recv(model_rd(252, 16), 16, "R6 rdb"); cs_hi();
    check("R8 raw buf", {27'd0, raw}, 5'b10011);
    clr_all();

    // R5 wrap with 9-bit store address, R7 dummy on 5-bit return address
    wr_alen = 6'd8; rd_alen = 6'd4;
    cs_lo(); send(2, 8, "R5 cmd"); send(9'h1FE, 9, "R5 addr"); send(16'h9C35, 16, "R5 wrap");
    cs_hi(); model_wr(510, 16'h9C35, 16);
    buf_len = 9'd3; dum_en = 4'b0001; dum_len[0] = 8'd2; int_en = '0;
    cs_lo(); send(3, 8, "R7 cmd"); send(0, 5, "R5 addr"); send(3'b111, 3, "R7 dummy");
    recv(model_rd(0, 4), 4, "R5 R6 wrap rdb"); cs_hi();
    check("R8 masked irq", {31'd0, irq}, 0);
    check("R8 raw masked", {27'd0, raw}, 5'b10011);
    int_en = 5'h1F; buf_len = 9'd15; wr_alen = 6'd7; rd_alen = 6'd7;
    clr_all();

    // R7 dummy ahead of status store
    dum_en = 4'b1000; dum_len[3] = 8'd0;
    cs_lo(); send(1, 8, "R7 cmd"); send(1, 1, "R7 dummy"); send(8'h3C, 8, "R7"); cs_hi();
    check("R7 sts", sts, 32'h3C);
    dum_en = '0;

    // R3 programmed codes
    cmd_def = 1'b1; cmd_code[0] = 8'h0B; cmd_code[1] = 8'h12;
    cmd_code[2] = 8'h05; cmd_code[3] = 8'h9E;
    cs_lo(); send(8'h9E, 8, "R3 cmd"); send(8'h66, 8, "R3"); cs_hi();
    check("R3 sts", sts, 32'h66);
    cs_lo(); send(8'h05, 8, "R3 cmd"); recv(8'h66, 8, "R3 rds"); cs_hi();
    clr_all();
    cs_lo(); send(8'h01, 8, "R10 cmd"); send(16'hFFFF, 16, "R10 idle"); cs_hi();
    check("R10 sts prog", sts, 32'h66);
    check("R10 raw prog", {27'd0, raw}, 0);
    cmd_def = 1'b0;

    // R10 fixed-mode unknown code
    cs_lo(); send(8'h07, 8, "R10 cmd"); send(16'hFFFF, 16, "R10 idle"); cs_hi();
    check("R10 sts", sts, 32'h66);
    check("R10 raw", {27'd0, raw}, 0);

    // R11 abort mid-status
    cs_lo(); send(1, 8, "R11 cmd"); send(4'hF, 4, "R11"); cs_hi();
    check("R11 raw", {27'd0, raw}, 0);
    check("R11 sts kept", sts, 32'hF6);
    cs_lo(); send(4, 8, "R11 cmd"); recv(8'hF6, 8, "R11 restart"); cs_hi();
    clr_all();

    // R9 falling-edge sampling
    edge_sel = 1'b0;
    cs_lo(); send(1, 8, "R9 cmd"); send(8'h5A, 8, "R9"); cs_hi();
    check("R9 sts", sts, 32'h5A);
    cs_lo(); send(4, 8, "R9 cmd"); recv(8'h5A, 8, "R9 rds"); cs_hi();
    check("R9 raw", {27'd0, raw}, 5'b11100);

    repeat (4) @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_err);
    $finish;
  end
endmodule